// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It runs a nine-instruction subset: three-register arithmetic and logic (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and an unconditional jump. The program counter, a 32 x 32 register file, a word-indexed instruction array, a word-indexed data array, the ALU, the control decoder and the next-PC selector all sit inside it.

The only ports are the clock, a synchronous reset and a debug port. The debug port shows the current program counter and the contents of one register chosen by a select input. A test environment fills both memory arrays by hierarchical reference before it releases reset. Each instruction then commits its register write, memory write and program-counter update on the next rising clock edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0x00000000 and every register is cleared to zero.
- R2: Apart from a jump or a taken branch, each rising edge advances the program counter by 4. The instruction word is read from the instruction array at index pc[IMEM_AW+1:2].
- R3: With opcode 0x00 (bits 31:26) and shamt (bits 10:6) equal to zero, funct (bits 5:0) selects the operation on rs (25:21) and rt (20:16). The codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x2A signed set-less-than (result 1 or 0). The result is written to rd (15:11).
- R4: Register 0 always reads as zero, and writes aimed at it have no effect.
- R5: Opcode 0x23 loads the data word at rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. The data array is indexed by address bits [DMEM_AW+1:2], and negative offsets work.
- R6: Opcode 0x2B stores the contents of rt at rs plus the sign-extended immediate, and it writes no register.
- R7: Opcode 0x04 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two, so both forward and backward branches work. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to the upper four bits of PC+4, followed by the 26-bit target field (bits 25:0), followed by two zero bits. The jump select has priority over the branch select.
- R9: Any other opcode, an R-format word with an unlisted funct, or an R-format word with a non-zero shamt writes neither a register nor memory, and the PC advances by 4.
- R10: A register written by one instruction holds the new value for the very next instruction.
- R11: `dbg_pc` equals the program counter, and `dbg_reg` shows the register selected by `dbg_sel` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | RF_AW | Register index shown on `dbg_reg` |
| dbg_pc | output | XLEN | Current program counter |
| dbg_reg | output | XLEN | Contents of the register chosen by `dbg_sel` |

## Verification
Each instruction's effects (the register write, the memory write and the new PC) become visible one rising edge after that instruction reaches the PC. After n rising edges with reset low, exactly n instructions have retired. The bench releases reset on a falling edge, moves forward in whole falling edges, and reads the debug port a fraction of a nanosecond after a falling edge. Every sample therefore sees a settled state, long before the next commit. Memory contents are read back through load instructions and the register debug view, so no check depends on internal state.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
   // opcode field values, bits 31:26
   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_JUMP  = 6'h02;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;

   // funct field values, bits 5:0
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   // ALU selector: upper bits mark operand inversion, lower bits the unit
   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_fn_e;

   // first-level class from the opcode
   typedef enum logic [1:0] {
      AC_ADD   = 2'b00,
      AC_SUB   = 2'b01,
      AC_FUNCT = 2'b10,
      AC_NONE  = 2'b11
   } alu_class_e;

   typedef struct packed {
      logic    dst_rd;   // destination from rd instead of rt
      logic    src_imm;  // second operand is the extended immediate
      logic    wb_mem;   // write-back from data memory
      logic    rf_we;
      logic    dm_re;
      logic    dm_we;
      logic    branch;
      logic    jump;
      alu_fn_e alu_fn;
   } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [4:0] shamt,
   input  logic [5:0] funct,
   output ctrl_t      ctl
);
   alu_class_e cls;
   logic       funct_ok;

   always_comb begin
      ctl        = '0;
      ctl.alu_fn = ALU_ADD;
      cls        = AC_NONE;
      funct_ok   = 1'b0;

      // main decoder: opcode only
      unique case (opcode)
         OPC_RTYPE: begin
            ctl.dst_rd = 1'b1;
            ctl.rf_we  = 1'b1;
            cls        = AC_FUNCT;
         end
         OPC_LOAD: begin
            ctl.src_imm = 1'b1;
            ctl.wb_mem  = 1'b1;
            ctl.rf_we   = 1'b1;
            ctl.dm_re   = 1'b1;
            cls         = AC_ADD;
         end
         OPC_STORE: begin
            ctl.src_imm = 1'b1;
            ctl.dm_we   = 1'b1;
            cls         = AC_ADD;
         end
         OPC_BEQ: begin
            ctl.branch = 1'b1;
            cls        = AC_SUB;
         end
         OPC_JUMP: ctl.jump = 1'b1;
         default: ;
      endcase

      // second level: class plus funct
      unique case (cls)
         AC_ADD: ctl.alu_fn = ALU_ADD;
         AC_SUB: ctl.alu_fn = ALU_SUB;
         AC_FUNCT: begin
            funct_ok = 1'b1;
            unique case (funct)
               FN_ADD:  ctl.alu_fn = ALU_ADD;
               FN_SUB:  ctl.alu_fn = ALU_SUB;
               FN_AND:  ctl.alu_fn = ALU_AND;
               FN_OR:   ctl.alu_fn = ALU_OR;
               FN_SLT:  ctl.alu_fn = ALU_SLT;
               default: funct_ok   = 1'b0;
            endcase
            if (!funct_ok || (shamt != 5'd0))
               ctl.rf_we = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] op_a,
   input  logic [XLEN-1:0] op_b,
   input  alu_fn_e         fn,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      unique case (fn)
         ALU_AND: y = op_a & op_b;
         ALU_OR:  y = op_a | op_b;
         ALU_ADD: y = op_a + op_b;
         ALU_SUB: y = op_a - op_b;
         ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
   parameter int XLEN   = 32,
   parameter int AW     = 5,
   parameter int NPORTS = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NPORTS-1:0][AW-1:0]  ra,
   output logic [NPORTS-1:0][XLEN-1:0] rd,
   input  logic                       we,
   input  logic [AW-1:0]              wa,
   input  logic [XLEN-1:0]            wd
);
   localparam int NREGS = 1 << AW;

   logic [XLEN-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++)
            regs[i] <= '0;
      end else if (we && (wa != '0)) begin
         regs[wa] <= wd;
      end
   end

   // combinational read ports, index 0 forced to zero
   for (genvar p = 0; p < NPORTS; p++) begin : g_rd
      assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
   end
endmodule

// File: rtl/sc_nextpc.sv
`timescale 1ns/1ps
module sc_nextpc #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] imm_ext,
   input  logic [25:0]     jtgt,
   input  logic            branch,
   input  logic            zero,
   input  logic            jump,
   output logic [XLEN-1:0] pc_next
);
   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;

   assign seq_pc = pc + STEP;
   assign br_pc  = seq_pc + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_pc = {seq_pc[XLEN-1:XLEN-4], jtgt, 2'b00};

   always_comb begin
      if (jump)
         pc_next = jmp_pc;
      else if (branch && zero)
         pc_next = br_pc;
      else
         pc_next = seq_pc;
   end
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IMEM_AW = 6,
   parameter int DMEM_AW = 6,
   parameter int RF_AW   = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [RF_AW-1:0] dbg_sel,
   output logic [XLEN-1:0]  dbg_pc,
   output logic [XLEN-1:0]  dbg_reg
);
   localparam int IMEM_DEPTH = 1 << IMEM_AW;
   localparam int DMEM_DEPTH = 1 << DMEM_AW;
   localparam int RD_PORTS   = 3;

   // elaboration-time parameter checks
   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32, the instruction format is fixed");
   end
   if (RF_AW != 5) begin : g_bad_rf
      $error("sc_core: RF_AW must be 5 to match the 5-bit register fields");
   end
   if (IMEM_AW < 1 || IMEM_AW > 12) begin : g_bad_imem
      $error("sc_core: IMEM_AW out of range 1..12");
   end
   if (DMEM_AW < 1 || DMEM_AW > 12) begin : g_bad_dmem
      $error("sc_core: DMEM_AW out of range 1..12");
   end

   // storage
   logic [XLEN-1:0] imem [IMEM_DEPTH];
   logic [XLEN-1:0] dmem [DMEM_DEPTH];
   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_next;

   initial begin
      for (int i = 0; i < IMEM_DEPTH; i++)
         imem[i] = '0;
   end

   // fetch and field split
   logic [XLEN-1:0]    instr;
   logic [RF_AW-1:0]   f_rs, f_rt, f_rd;
   logic [XLEN-1:0]    imm_ext;
   ctrl_t              ctl;

   assign instr   = imem[pc_q[IMEM_AW+1:2]];
   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

   sc_decode u_dec (
      .opcode (instr[31:26]),
      .shamt  (instr[10:6]),
      .funct  (instr[5:0]),
      .ctl    (ctl)
   );

   // register file: port 0 rs, port 1 rt, port 2 debug
   logic [RD_PORTS-1:0][RF_AW-1:0] rf_ra;
   logic [RD_PORTS-1:0][XLEN-1:0]  rf_rd;
   logic [RF_AW-1:0]               rf_wa;
   logic [XLEN-1:0]                rf_wd;

   assign rf_ra[0] = f_rs;
   assign rf_ra[1] = f_rt;
   assign rf_ra[2] = dbg_sel;
   assign rf_wa    = ctl.dst_rd ? f_rd : f_rt;

   sc_regfile #(
      .XLEN   (XLEN),
      .AW     (RF_AW),
      .NPORTS (RD_PORTS)
   ) u_rf (
      .clk (clk),
      .rst (rst),
      .ra  (rf_ra),
      .rd  (rf_rd),
      .we  (ctl.rf_we),
      .wa  (rf_wa),
      .wd  (rf_wd)
   );

   // execute
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_y;
   logic            alu_zero;

   assign alu_b = ctl.src_imm ? imm_ext : rf_rd[1];

   sc_alu #(.XLEN(XLEN)) u_alu (
      .op_a (rf_rd[0]),
      .op_b (alu_b),
      .fn   (ctl.alu_fn),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data memory
   logic [DMEM_AW-1:0] dm_idx;
   logic [XLEN-1:0]    dm_rdata;

   assign dm_idx   = alu_y[DMEM_AW+1:2];
   assign dm_rdata = ctl.dm_re ? dmem[dm_idx] : '0;

   always_ff @(posedge clk) begin
      if (!rst && ctl.dm_we)
         dmem[dm_idx] <= rf_rd[1];
   end

   assign rf_wd = ctl.wb_mem ? dm_rdata : alu_y;

   // next PC
   sc_nextpc #(.XLEN(XLEN)) u_npc (
      .pc      (pc_q),
      .imm_ext (imm_ext),
      .jtgt    (instr[25:0]),
      .branch  (ctl.branch),
      .zero    (alu_zero),
      .jump    (ctl.jump),
      .pc_next (pc_next)
   );

   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   assign dbg_pc  = pc_q;
   assign dbg_reg = rf_rd[2];
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk
   import sc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int RF_AW = 5
) (
   input logic             clk,
   input logic             rst,
   input logic [XLEN-1:0]  pc,
   input logic [XLEN-1:0]  instr,
   input logic             rf_we,
   input logic             dm_we,
   input logic [RF_AW-1:0] dbg_sel,
   input logic [XLEN-1:0]  dbg_reg
);
   localparam logic [XLEN-1:0] FOUR = XLEN'(4);

   logic [5:0]      op;
   logic [XLEN-1:0] seq;
   logic [XLEN-1:0] boff;

   assign op   = instr[31:26];
   assign seq  = pc + FOUR;
   assign boff = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

   AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc == '0)); // R1

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00); // R2

   AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
      (op != OPC_BEQ && op != OPC_JUMP) |=> (pc == $past(seq))); // R2

   AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (dbg_sel == '0) |-> (dbg_reg == '0)); // R4

   AST_STORE_NO_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_STORE) |-> !rf_we); // R6

   AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_BEQ) |=> ((pc == $past(seq)) || (pc == $past(seq) + $past(boff)))); // R7

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_JUMP) |=> (pc == {$past(seq[31:28]), $past(instr[25:0]), 2'b00})); // R8

   AST_DMEM_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
      dm_we |-> (op == OPC_STORE)); // R9
endmodule

bind sc_core sc_core_chk #(
   .XLEN  (XLEN),
   .RF_AW (RF_AW)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .pc      (pc_q),
   .instr   (instr),
   .rf_we   (ctl.rf_we),
   .dm_we   (ctl.dm_we),
   .dbg_sel (dbg_sel),
   .dbg_reg (dbg_reg)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
   localparam int IWORDS = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_pc;
   logic [31:0] dbg_reg;

   int n_chk = 0;
   int n_bad = 0;

   sc_core u_sc_core (
      .clk     (clk),
      .rst     (rst),
      .dbg_sel (dbg_sel),
      .dbg_pc  (dbg_pc),
      .dbg_reg (dbg_reg)
   );

   always #2.5 clk = ~clk;

   // encoders
   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [4:0] sh,
                                         input logic [5:0] fn);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(input logic [25:0] tgt);
      return {6'h02, tgt};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_reg(input string req, input logic [4:0] r, input logic [31:0] exp);
      dbg_sel = r;
      #0.1;
      check(req, $sformatf("reg %0d", r), dbg_reg, exp);
   endtask

   task automatic check_pc(input string req, input logic [31:0] exp);
      #0.1;
      check(req, "pc", dbg_pc, exp);
   endtask

   // hold reset, wait one edge, clear the instruction array
   task automatic prog_open();
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < IWORDS; i++)
         u_sc_core.imem[i] = '0;
   endtask

   task automatic iput(input int idx, input logic [31:0] w);
      u_sc_core.imem[idx] = w;
   endtask

   task automatic dput(input int idx, input logic [31:0] w);
      u_sc_core.dmem[idx] <= w;
   endtask

   task automatic prog_start();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R3 R10 R4 R2: arithmetic and logic with back-to-back dependencies
   task automatic t_alu();
      prog_open();
      dput(0, 32'd7);
      dput(1, 32'hFFFF_FFFD);
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h23, 5'd0, 5'd2, 16'd4));
      iput(2, enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20));
      iput(3, enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h22));
      iput(4, enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h24));
      iput(5, enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h25));
      iput(6, enc_r(5'd2, 5'd1, 5'd7, 5'd0, 6'h2A));
      iput(7, enc_r(5'd1, 5'd2, 5'd8, 5'd0, 6'h2A));
      iput(8, enc_r(5'd1, 5'd1, 5'd0, 5'd0, 6'h20));
      prog_start();
      step(9);
      check_pc("R2", 32'd36);
      check_reg("R10", 5'd3, 32'd4);
      check_reg("R3", 5'd4, 32'd10);
      check_reg("R3", 5'd5, 32'd5);
      check_reg("R3", 5'd6, 32'hFFFF_FFFF);
      check_reg("R3", 5'd7, 32'd1);
      check_reg("R3", 5'd8, 32'd0);
      check_reg("R4", 5'd0, 32'd0);
      check_reg("R11", 5'd1, 32'd7);
   endtask

   // R1: reset clears PC and registers left over from the previous program
   task automatic t_reset();
      prog_open();
      check_pc("R1", 32'd0);
      check_reg("R1", 5'd3, 32'd0);
      check_reg("R1", 5'd6, 32'd0);
      prog_start();
      step(3);
      check_pc("R2", 32'd12);
      check_reg("R9", 5'd0, 32'd0);
   endtask

   // R5 R6: load with negative offset, store, read back
   task automatic t_mem();
      prog_open();
      dput(2, 32'd24);
      dput(5, 32'h1234_5678);
      dput(7, 32'd0);
      iput(0, enc_i(6'h23, 5'd0, 5'd3, 16'd8));
      iput(1, enc_i(6'h23, 5'd3, 5'd4, 16'hFFFC));
      iput(2, enc_i(6'h2B, 5'd3, 5'd4, 16'd4));
      iput(3, enc_i(6'h23, 5'd0, 5'd5, 16'd28));
      prog_start();
      step(4);
      check_pc("R2", 32'd16);
      check_reg("R5", 5'd3, 32'd24);
      check_reg("R5", 5'd4, 32'h1234_5678);
      check_reg("R6", 5'd5, 32'h1234_5678);
   endtask

   // R7 R8: taken forward, not taken, jump, taken backward
   task automatic t_flow();
      prog_open();
      dput(0, 32'd5);
      iput(0,  enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1,  enc_i(6'h23, 5'd0, 5'd2, 16'd0));
      iput(2,  enc_i(6'h04, 5'd1, 5'd2, 16'd3));
      iput(3,  enc_r(5'd1, 5'd1, 5'd3, 5'd0, 6'h20));
      iput(4,  enc_r(5'd1, 5'd1, 5'd3, 5'd0, 6'h20));
      iput(5,  enc_r(5'd1, 5'd1, 5'd3, 5'd0, 6'h20));
      iput(6,  enc_i(6'h04, 5'd1, 5'd0, 16'd5));
      iput(7,  enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h20));
      iput(8,  enc_j(26'd12));
      iput(9,  enc_r(5'd1, 5'd1, 5'd5, 5'd0, 6'h20));
      iput(10, enc_r(5'd1, 5'd1, 5'd6, 5'd0, 6'h20));
      iput(11, enc_j(26'd14));
      iput(12, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFD));
      iput(13, enc_r(5'd1, 5'd1, 5'd5, 5'd0, 6'h20));
      iput(14, enc_r(5'd2, 5'd2, 5'd7, 5'd0, 6'h20));
      prog_start();
      step(3);
      check_pc("R7", 32'd24);
      step(2);
      check_pc("R7", 32'd32);
      step(1);
      check_pc("R8", 32'd48);
      step(1);
      check_pc("R7", 32'd40);
      step(3);
      check_pc("R8", 32'd60);
      check_reg("R7", 5'd3, 32'd0);
      check_reg("R7", 5'd4, 32'd10);
      check_reg("R8", 5'd5, 32'd0);
      check_reg("R7", 5'd6, 32'd10);
      check_reg("R8", 5'd7, 32'd10);
   endtask

   // R9: unsupported encodings change nothing but the PC
   task automatic t_unknown();
      prog_open();
      dput(0, 32'd9);
      iput(0, enc_i(6'h23, 5'd0, 5'd1, 16'd0));
      iput(1, enc_i(6'h08, 5'd0, 5'd1, 16'd5));
      iput(2, enc_r(5'd1, 5'd1, 5'd2, 5'd0, 6'h27));
      iput(3, enc_r(5'd1, 5'd1, 5'd4, 5'd3, 6'h20));
      iput(4, enc_i(6'h29, 5'd0, 5'd1, 16'd0));
      iput(5, enc_i(6'h23, 5'd0, 5'd3, 16'd0));
      prog_start();
      step(6);
      check_pc("R9", 32'd24);
      check_reg("R9", 5'd1, 32'd9);
      check_reg("R9", 5'd2, 32'd0);
      check_reg("R9", 5'd4, 32'd0);
      check_reg("R9", 5'd3, 32'd9);
   endtask

   initial begin : watchdog
      #(200000 * 5.0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      #1;
      t_alu();
      t_reset();
      t_mem();
      t_flow();
      t_unknown();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule